// File: doc/BRIEF.md
# Serial Flash Chip-Select Timing Controller

This block owns the active-low chip select of a serial flash port and decides when the shift sequencer may clock the bus. A sequencer raises a one-cycle transfer request. The block asserts chip select and waits out a configurable setup interval. It then opens a clock-enable window, which lasts until the sequencer reports that the final bit has moved. The block then holds chip select through a configurable hold interval. After a release it keeps chip select high for at least a programmable deselect gap before it starts the next access.

All timing is counted in half serial clock periods. One cycle of `clk` is one half period, so a clock-enable window of N cycles is N/2 serial clocks. This makes the half-period setup and hold choices exact. After an access, chip select may optionally stay asserted for 32 or 128 serial clocks, or with no limit. During that time a request flagged as sequential restarts the clock window at once, with no new setup. A request not flagged as sequential closes the transaction, runs the gap, and then starts its own access without being asked again. A mode-change release input drops chip select through the normal hold and gap timing.

Top module: `fcs_timing_ctl`

## Requirements
- R1: After reset `cs_n_o` is 1, `sck_en_o` is 0 and `ready_o` is 1.
- R2: A request accepted while idle drives `cs_n_o` low on the next cycle. `sck_en_o` then stays low for exactly 1 cycle when `cfg_setup_long_i`=0, or 3 cycles when it is 1, before it rises.
- R3: `sck_en_o` stays high from the end of setup until the cycle in which `xfer_done_i` is sampled high, and falls on the next cycle.
- R4: After the clock window closes, `cs_n_o` stays low with `sck_en_o` low for exactly 1 cycle when `cfg_hold_long_i`=0, or 3 cycles when it is 1.
- R5: Once `cs_n_o` rises, it stays high with `ready_o` low for exactly 2*(`cfg_gap_i`+1) cycles, and then `ready_o` returns to 1.
- R6: A request while `ready_o` is 0 is ignored. It neither shortens the gap nor starts an access afterwards.
- R7: With `cfg_ext_i`=1 (or 2), `cs_n_o` stays low with `ready_o` high and `sck_en_o` low for 64 (or 256) cycles after the hold, and then releases into the gap. With `cfg_ext_i`=0 the hold goes straight to the gap.
- R8: With `cfg_ext_i`=3, `cs_n_o` stays low after the hold until a request or release arrives.
- R9: A request with `xfer_seq_i`=1 during the extension window raises `sck_en_o` on the next cycle, with `cs_n_o` kept low and no setup interval.
- R10: A request with `xfer_seq_i`=0 during the extension window raises `cs_n_o` on the next cycle and runs the full gap. The access then starts its setup without a further request.
- R11: `cs_release_i` during the extension window raises `cs_n_o` on the next cycle and starts the gap. During setup or the clock window it ends the window, runs the hold and then the gap, and skips any extension.
- R12: `sck_en_o` is never high while `cs_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per half serial clock period |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_req_i | input | 1 | One-cycle transfer request, taken only while ready_o is 1 |
| xfer_seq_i | input | 1 | Request continues at the next sequential address |
| xfer_done_i | input | 1 | Last serial clock edge of the access has occurred |
| cs_release_i | input | 1 | Mode-change request to drop chip select |
| cfg_setup_long_i | input | 1 | Setup: 0 gives a half period, 1 gives one and a half |
| cfg_hold_long_i | input | 1 | Hold: 0 gives a half period, 1 gives one and a half |
| cfg_gap_i | input | GAP_W | Minimum deselect gap code, n means n+1 serial clocks |
| cfg_ext_i | input | 2 | Extension: 0 none, 1 short, 2 long, 3 unlimited |
| cs_n_o | output | 1 | Active-low chip select |
| sck_en_o | output | 1 | Serial clock may toggle |
| ready_o | output | 1 | A request can be accepted this cycle |

## Verification
The bound checker checks on every cycle the relations that need only a short history at the ports. It checks that the clock is never enabled with chip select high. It checks that each clock window opens only after chip select has been low for the selected setup time, and that each release follows at least the selected hold time after the last enabled cycle. It also checks that a re-selection never comes before the deselect gap, that a release in the extension window deselects on the next cycle, and that a sequential continuation enables the clock at once. The exact lengths of each phase need the directed scenarios: that setup, hold, gap and the 64- and 256-cycle extensions are exact rather than minimums, that requests during the gap leave no trace, and that a non-sequential request restarts by itself after the gap.

// File: rtl/fcs_timing_pkg.sv
package fcs_timing_pkg;

   typedef enum logic [2:0] {
      FCS_IDLE,
      FCS_SETUP,
      FCS_CLOCK,
      FCS_HOLD,
      FCS_LINGER,
      FCS_GAP
   } fcs_state_e;

   localparam logic [1:0] LINGER_NONE    = 2'd0;
   localparam logic [1:0] LINGER_SHORT   = 2'd1;
   localparam logic [1:0] LINGER_LONG    = 2'd2;
   localparam logic [1:0] LINGER_FOREVER = 2'd3;

endpackage

// File: rtl/fcs_len_decode.sv
module fcs_len_decode #(
   parameter int GAP_W      = 4,
   parameter int CNT_W      = 8,
   parameter int EXT_SHORT  = 32,
   parameter int EXT_LONG   = 128,
   parameter int SHORT_HALF = 1,
   parameter int LONG_HALF  = 3
) (
   input  logic             setup_long_i,
   input  logic             hold_long_i,
   input  logic [GAP_W-1:0] gap_code_i,
   input  logic [1:0]       ext_code_i,
   output logic [CNT_W-1:0] setup_m1_o,
   output logic [CNT_W-1:0] hold_m1_o,
   output logic [CNT_W-1:0] gap_m1_o,
   output logic [CNT_W-1:0] ext_m1_o,
   output logic             ext_none_o,
   output logic             ext_forever_o
);
   import fcs_timing_pkg::*;

   localparam logic [CNT_W-1:0] SHORT_M1   = CNT_W'(SHORT_HALF - 1);
   localparam logic [CNT_W-1:0] LONG_M1    = CNT_W'(LONG_HALF - 1);
   localparam logic [CNT_W-1:0] EXT_S_M1   = CNT_W'(2 * EXT_SHORT - 1);
   localparam logic [CNT_W-1:0] EXT_L_M1   = CNT_W'(2 * EXT_LONG - 1);

   // setup and hold share one pair of lengths, so one mux each
   assign setup_m1_o = setup_long_i ? LONG_M1 : SHORT_M1;
   assign hold_m1_o  = hold_long_i  ? LONG_M1 : SHORT_M1;

   // gap of (code+1) serial clocks is 2*code+2 half periods, minus one
   assign gap_m1_o   = CNT_W'({gap_code_i, 1'b1});

   assign ext_m1_o      = (ext_code_i == LINGER_SHORT) ? EXT_S_M1 : EXT_L_M1;
   assign ext_none_o    = (ext_code_i == LINGER_NONE);
   assign ext_forever_o = (ext_code_i == LINGER_FOREVER);

endmodule

// File: rtl/fcs_phase_timer.sv
module fcs_phase_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             expired_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/fcs_seq_fsm.sv
module fcs_seq_fsm #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             seq_i,
   input  logic             done_i,
   input  logic             release_i,
   input  logic [CNT_W-1:0] setup_m1_i,
   input  logic [CNT_W-1:0] hold_m1_i,
   input  logic [CNT_W-1:0] gap_m1_i,
   input  logic [CNT_W-1:0] ext_m1_i,
   input  logic             ext_none_i,
   input  logic             ext_forever_i,
   input  logic             expired_i,
   output logic             load_o,
   output logic [CNT_W-1:0] load_val_o,
   output logic             cs_n_o,
   output logic             sck_en_o,
   output logic             ready_o
);
   import fcs_timing_pkg::*;

   fcs_state_e state_q, state_d;
   logic       pend_q, pend_d;     // deferred non-sequential request
   logic       force_q, force_d;   // release seen: skip extension

   always_comb begin
      state_d    = state_q;
      pend_d     = pend_q;
      force_d    = force_q;
      load_o     = 1'b0;
      load_val_o = '0;

      unique case (state_q)
         FCS_IDLE: begin
            if (req_i) begin
               state_d    = FCS_SETUP;
               load_o     = 1'b1;
               load_val_o = setup_m1_i;
            end
         end

         FCS_SETUP, FCS_CLOCK: begin
            if (release_i) begin
               state_d    = FCS_HOLD;
               force_d    = 1'b1;
               load_o     = 1'b1;
               load_val_o = hold_m1_i;
            end else if (state_q == FCS_SETUP) begin
               if (expired_i) state_d = FCS_CLOCK;
            end else if (done_i) begin
               state_d    = FCS_HOLD;
               load_o     = 1'b1;
               load_val_o = hold_m1_i;
            end
         end

         FCS_HOLD: begin
            if (release_i) force_d = 1'b1;
            if (expired_i) begin
               load_o = 1'b1;
               if (force_q || release_i || ext_none_i) begin
                  state_d    = FCS_GAP;
                  force_d    = 1'b0;
                  load_val_o = gap_m1_i;
               end else begin
                  state_d    = FCS_LINGER;
                  load_val_o = ext_m1_i;
               end
            end
         end

         FCS_LINGER: begin
            if (release_i) begin
               state_d    = FCS_GAP;
               load_o     = 1'b1;
               load_val_o = gap_m1_i;
            end else if (req_i && seq_i) begin
               state_d = FCS_CLOCK;
            end else if (req_i) begin
               state_d    = FCS_GAP;
               pend_d     = 1'b1;
               load_o     = 1'b1;
               load_val_o = gap_m1_i;
            end else if (!ext_forever_i && expired_i) begin
               state_d    = FCS_GAP;
               load_o     = 1'b1;
               load_val_o = gap_m1_i;
            end
         end

         FCS_GAP: begin
            if (expired_i) begin
               pend_d = 1'b0;
               if (pend_q) begin
                  state_d    = FCS_SETUP;
                  load_o     = 1'b1;
                  load_val_o = setup_m1_i;
               end else begin
                  state_d = FCS_IDLE;
               end
            end
         end

         default: state_d = FCS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FCS_IDLE;
         pend_q  <= 1'b0;
         force_q <= 1'b0;
      end else begin
         state_q <= state_d;
         pend_q  <= pend_d;
         force_q <= force_d;
      end
   end

   assign cs_n_o   = (state_q == FCS_IDLE) || (state_q == FCS_GAP);
   assign sck_en_o = (state_q == FCS_CLOCK);
   assign ready_o  = (state_q == FCS_IDLE) || (state_q == FCS_LINGER);

endmodule

// File: rtl/fcs_timing_ctl.sv
module fcs_timing_ctl #(
   parameter int GAP_W      = 4,
   parameter int EXT_SHORT  = 32,
   parameter int EXT_LONG   = 128,
   parameter int SHORT_HALF = 1,
   parameter int LONG_HALF  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xfer_req_i,
   input  logic             xfer_seq_i,
   input  logic             xfer_done_i,
   input  logic             cs_release_i,
   input  logic             cfg_setup_long_i,
   input  logic             cfg_hold_long_i,
   input  logic [GAP_W-1:0] cfg_gap_i,
   input  logic [1:0]       cfg_ext_i,
   output logic             cs_n_o,
   output logic             sck_en_o,
   output logic             ready_o
);
   localparam int EXT_BITS = $clog2(2 * EXT_LONG);
   localparam int GAP_BITS = GAP_W + 1;
   localparam int CNT_W    = (EXT_BITS > GAP_BITS) ? EXT_BITS : GAP_BITS;

   generate
      if (SHORT_HALF < 1) begin : g_bad_short
         $error("SHORT_HALF must be at least one half period");
      end
      if (LONG_HALF <= SHORT_HALF) begin : g_bad_long
         $error("LONG_HALF must exceed SHORT_HALF");
      end
      if (EXT_SHORT < 1 || EXT_LONG <= EXT_SHORT) begin : g_bad_ext
         $error("extension lengths must satisfy 0 < EXT_SHORT < EXT_LONG");
      end
      if (LONG_HALF > (1 << CNT_W)) begin : g_bad_width
         $error("phase counter too narrow for LONG_HALF");
      end
   endgenerate

   logic [CNT_W-1:0] setup_m1, hold_m1, gap_m1, ext_m1;
   logic             ext_none, ext_forever;
   logic             tmr_load, tmr_expired;
   logic [CNT_W-1:0] tmr_val;

   fcs_len_decode #(
      .GAP_W      (GAP_W),
      .CNT_W      (CNT_W),
      .EXT_SHORT  (EXT_SHORT),
      .EXT_LONG   (EXT_LONG),
      .SHORT_HALF (SHORT_HALF),
      .LONG_HALF  (LONG_HALF)
   ) u_decode (
      .setup_long_i  (cfg_setup_long_i),
      .hold_long_i   (cfg_hold_long_i),
      .gap_code_i    (cfg_gap_i),
      .ext_code_i    (cfg_ext_i),
      .setup_m1_o    (setup_m1),
      .hold_m1_o     (hold_m1),
      .gap_m1_o      (gap_m1),
      .ext_m1_o      (ext_m1),
      .ext_none_o    (ext_none),
      .ext_forever_o (ext_forever)
   );

   fcs_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .expired_o  (tmr_expired)
   );

   fcs_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_i         (xfer_req_i),
      .seq_i         (xfer_seq_i),
      .done_i        (xfer_done_i),
      .release_i     (cs_release_i),
      .setup_m1_i    (setup_m1),
      .hold_m1_i     (hold_m1),
      .gap_m1_i      (gap_m1),
      .ext_m1_i      (ext_m1),
      .ext_none_i    (ext_none),
      .ext_forever_i (ext_forever),
      .expired_i     (tmr_expired),
      .load_o        (tmr_load),
      .load_val_o    (tmr_val),
      .cs_n_o        (cs_n_o),
      .sck_en_o      (sck_en_o),
      .ready_o       (ready_o)
   );

endmodule

// File: rtl/fcs_timing_chk.sv
module fcs_timing_chk #(
   parameter int GAP_W      = 4,
   parameter int SHORT_HALF = 1,
   parameter int LONG_HALF  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             xfer_req_i,
   input logic             xfer_seq_i,
   input logic             cs_release_i,
   input logic             cfg_setup_long_i,
   input logic             cfg_hold_long_i,
   input logic [GAP_W-1:0] cfg_gap_i,
   input logic             cs_n_o,
   input logic             sck_en_o,
   input logic             ready_o
);
   logic [7:0] low_run, since_sck, high_run;
   logic       was_selected;

   // saturating run-length counters observed at the ports
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run      <= '0;
         since_sck    <= '0;
         high_run     <= '0;
         was_selected <= 1'b0;
      end else begin
         low_run   <= cs_n_o ? 8'd0 : ((low_run == 8'hFF) ? low_run : low_run + 8'd1);
         high_run  <= !cs_n_o ? 8'd0 : ((high_run == 8'hFF) ? high_run : high_run + 8'd1);
         since_sck <= sck_en_o ? 8'd0 : ((since_sck == 8'hFF) ? since_sck : since_sck + 8'd1);
         if (!cs_n_o) was_selected <= 1'b1;
      end
   end

   p_sck_needs_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
      sck_en_o |-> !cs_n_o);

   p_setup_time_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck_en_o) |-> int'(low_run) >= (cfg_setup_long_i ? LONG_HALF : SHORT_HALF));

   p_hold_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |-> int'(since_sck) >= (cfg_hold_long_i ? LONG_HALF : SHORT_HALF));

   p_min_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cs_n_o) && was_selected) |-> int'(high_run) >= 2 * (int'(cfg_gap_i) + 1));

   p_release_linger_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && !cs_n_o && cs_release_i) |=> cs_n_o);

   p_seq_continue_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && !cs_n_o && xfer_req_i && xfer_seq_i && !cs_release_i) |=> (sck_en_o && !cs_n_o));

endmodule

bind fcs_timing_ctl fcs_timing_chk #(
   .GAP_W      (GAP_W),
   .SHORT_HALF (SHORT_HALF),
   .LONG_HALF  (LONG_HALF)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .xfer_req_i       (xfer_req_i),
   .xfer_seq_i       (xfer_seq_i),
   .cs_release_i     (cs_release_i),
   .cfg_setup_long_i (cfg_setup_long_i),
   .cfg_hold_long_i  (cfg_hold_long_i),
   .cfg_gap_i        (cfg_gap_i),
   .cs_n_o           (cs_n_o),
   .sck_en_o         (sck_en_o),
   .ready_o          (ready_o)
);

// File: tb/fcs_timing_ctl_tb.sv
module fcs_timing_ctl_tb;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       xfer_req_i = 1'b0, xfer_seq_i = 1'b0, xfer_done_i = 1'b0, cs_release_i = 1'b0;
   logic       cfg_setup_long_i = 1'b0, cfg_hold_long_i = 1'b0;
   logic [3:0] cfg_gap_i = 4'd0;
   logic [1:0] cfg_ext_i = 2'd0;
   logic       cs_n_o, sck_en_o, ready_o;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fcs_timing_ctl u_dut (
      .clk              (clk),
      .rst_n            (rst_n),
      .xfer_req_i       (xfer_req_i),
      .xfer_seq_i       (xfer_seq_i),
      .xfer_done_i      (xfer_done_i),
      .cs_release_i     (cs_release_i),
      .cfg_setup_long_i (cfg_setup_long_i),
      .cfg_hold_long_i  (cfg_hold_long_i),
      .cfg_gap_i        (cfg_gap_i),
      .cfg_ext_i        (cfg_ext_i),
      .cs_n_o           (cs_n_o),
      .sck_en_o         (sck_en_o),
      .ready_o          (ready_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(); @(negedge clk); endtask

   // counts consecutive cycles where the outputs match the given triple
   task automatic count_state(input logic ecs, input logic esck, input logic erdy, output int n);
      n = 0;
      while (cs_n_o == ecs && sck_en_o == esck && ready_o == erdy && n < 1000) begin
         n++;
         step();
      end
   endtask

   task automatic pulse_req(input logic seq);
      xfer_req_i = 1'b1; xfer_seq_i = seq;
      step();
      xfer_req_i = 1'b0; xfer_seq_i = 1'b0;
   endtask

   task automatic pulse_release();
      cs_release_i = 1'b1;
      step();
      cs_release_i = 1'b0;
   endtask

   task automatic configure(input logic su, input logic ho, input int gap, input int ext);
      cfg_setup_long_i = su; cfg_hold_long_i = ho;
      cfg_gap_i = 4'(gap); cfg_ext_i = 2'(ext);
      repeat (40) step();
   endtask

   // clock window of len cycles, done given in its last cycle
   task automatic clock_window(input int len);
      for (int i = 0; i < len; i++) begin
         check(sck_en_o === 1'b1 && cs_n_o === 1'b0, "R3 window open", int'(sck_en_o), 1);
         if (i == len - 1) xfer_done_i = 1'b1;
         step();
         xfer_done_i = 1'b0;
      end
      check(sck_en_o === 1'b0, "R3 window closed after done", int'(sck_en_o), 0);
   endtask

   task automatic t_reset();
      check(cs_n_o === 1'b1, "R1 cs_n after reset", int'(cs_n_o), 1);
      check(sck_en_o === 1'b0, "R1 sck_en after reset", int'(sck_en_o), 0);
      check(ready_o === 1'b1, "R1 ready after reset", int'(ready_o), 1);
   endtask

   task automatic t_plain(input logic su, input logic ho, input int gap);
      int n;
      configure(su, ho, gap, 0);
      pulse_req(1'b0);
      count_state(1'b0, 1'b0, 1'b0, n);
      check(n == (su ? 3 : 1), "R2 setup length", n, su ? 3 : 1);
      clock_window(5);
      count_state(1'b0, 1'b0, 1'b0, n);
      check(n == (ho ? 3 : 1), "R4 hold length", n, ho ? 3 : 1);
      count_state(1'b1, 1'b0, 1'b0, n);
      check(n == 2 * (gap + 1), "R5 gap length", n, 2 * (gap + 1));
      check(ready_o === 1'b1 && cs_n_o === 1'b1, "R5 ready after gap", int'(ready_o), 1);
   endtask

   task automatic t_ignore_in_gap();
      int n;
      configure(1'b0, 1'b0, 7, 0);
      pulse_req(1'b0);
      count_state(1'b0, 1'b0, 1'b0, n);
      clock_window(2);
      count_state(1'b0, 1'b0, 1'b0, n);
      // first gap cycle observed: pulse a request now
      pulse_req(1'b0);
      count_state(1'b1, 1'b0, 1'b0, n);
      check(n == 15, "R6 gap unchanged by request", n, 15);
      n = 0;
      for (int i = 0; i < 12; i++) begin
         if (cs_n_o !== 1'b1 || ready_o !== 1'b1) n++;
         step();
      end
      check(n == 0, "R6 ignored request starts nothing", n, 0);
   endtask

   task automatic t_timed_ext(input int ext, input int exp_len);
      int n;
      configure(1'b0, 1'b0, 1, ext);
      pulse_req(1'b0);
      count_state(1'b0, 1'b0, 1'b0, n);
      clock_window(4);
      count_state(1'b0, 1'b0, 1'b0, n);
      count_state(1'b0, 1'b0, 1'b1, n);
      check(n == exp_len, "R7 extension length", n, exp_len);
      count_state(1'b1, 1'b0, 1'b0, n);
      check(n == 4, "R7 gap after extension", n, 4);
   endtask

   task automatic t_forever_seq_nonseq();
      int n;
      configure(1'b1, 1'b0, 2, 3);
      pulse_req(1'b0);
      count_state(1'b0, 1'b0, 1'b0, n);
      clock_window(4);
      count_state(1'b0, 1'b0, 1'b0, n);
      repeat (600) step();
      check(cs_n_o === 1'b0 && ready_o === 1'b1, "R8 held without limit", int'(cs_n_o), 0);
      // sequential continuation
      pulse_req(1'b1);
      check(sck_en_o === 1'b1 && cs_n_o === 1'b0, "R9 sequential starts clock at once", int'(sck_en_o), 1);
      clock_window(3);
      count_state(1'b0, 1'b0, 1'b0, n);
      check(ready_o === 1'b1 && cs_n_o === 1'b0, "R8 back in extension", int'(ready_o), 1);
      // non-sequential: release, gap, then its own setup
      pulse_req(1'b0);
      check(cs_n_o === 1'b1, "R10 non-sequential releases", int'(cs_n_o), 1);
      count_state(1'b1, 1'b0, 1'b0, n);
      check(n == 6, "R10 full gap", n, 6);
      count_state(1'b0, 1'b0, 1'b0, n);
      check(n == 3, "R10 setup without new request", n, 3);
      clock_window(2);
      count_state(1'b0, 1'b0, 1'b0, n);
      // release from extension window
      pulse_release();
      check(cs_n_o === 1'b1 && ready_o === 1'b0, "R11 release in extension", int'(cs_n_o), 1);
      count_state(1'b1, 1'b0, 1'b0, n);
      check(n == 6, "R11 gap after release", n, 6);
   endtask

   task automatic t_release_active();
      int n;
      configure(1'b0, 1'b1, 0, 3);
      pulse_req(1'b0);
      count_state(1'b0, 1'b0, 1'b0, n);
      repeat (2) step();
      check(sck_en_o === 1'b1, "R3 window open before release", int'(sck_en_o), 1);
      pulse_release();
      count_state(1'b0, 1'b0, 1'b0, n);
      check(n == 3, "R11 hold runs after release", n, 3);
      check(cs_n_o === 1'b1, "R11 extension skipped", int'(cs_n_o), 1);
      count_state(1'b1, 1'b0, 1'b0, n);
      check(n == 2, "R11 gap after release", n, 2);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_plain(1'b0, 1'b0, 0);
      t_plain(1'b1, 1'b1, 15);
      t_plain(1'b0, 1'b1, 5);
      t_ignore_in_gap();
      t_timed_ext(1, 64);
      t_timed_ext(2, 256);
      t_forever_seq_nonseq();
      t_release_active();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule